// File: doc/BRIEF.md
# Peripheral Freeze Controller with Set/Clear Access

This block keeps one freeze flag for each timer or peripheral unit on the chip and drives a registered freeze line to each unit. Software freezes units by writing ones to a set register and releases them by writing ones to a separate clear register. Zero bits in either write leave their flags alone, so software never needs a read-modify-write sequence.

Debug halts also freeze units, on top of the stored flags. When the main CPU is halted and its freeze enable is high, every implemented unit is frozen. When the main CPU is halted with its enable low, only the system watchdog is frozen and the other units follow their stored flags. A halt of the secondary CPU freezes every implemented unit when that CPU's freeze enable is high.

The system watchdog flag has one more rule. It cannot be set while the watchdog runs in its non-maskable-interrupt mode. Clearing it is always allowed.

Top module: `periph_freeze_ctrl`

## Requirements
- R1: After reset, every stored flag is 0, `frz_out` is 0, and reads at both register offsets return 0.
- R2: A write to byte offset 0x0 sets each stored flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R3: A write to byte offset 0x4 clears each stored flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: A read at offset 0x0 or 0x4 returns the stored flag vector in bits 10:0 with bits 31:11 at 0. A read at any other offset returns 0, and a write to any other offset changes no flag.
- R5: Bit 2 is reserved. It is never stored, always reads 0, and `frz_out[2]` is always 0.
- R6: While `wdog_nmi_mode` is 1, a set of bit 3 (system watchdog) is ignored. A clear of bit 3 still takes effect.
- R7: `frz_out` is registered. It equals the stored vector ORed with the halt terms of the previous cycle. The bit map is: 0 wake-up timer, 1 timer 1, 3 system watchdog, 4 USB, 5 DMA, 6 timer 2, 7 LED PWM, 8 timer 3, 9 timer 4, 10 secondary-CPU watchdog.
- R8: When `main_halted` and `main_frz_en` are both 1, all implemented outputs (mask 0x7FB) are 1 one cycle later.
- R9: When `main_halted` is 1 and `main_frz_en` is 0, `frz_out[3]` is 1 one cycle later. The other outputs follow their stored flags.
- R10: When `sec_halted` and `sec_frz_en` are both 1, all implemented outputs are 1 one cycle later. When `sec_halted` is 1 and `sec_frz_en` is 0, the secondary halt has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| main_halted | input | 1 | Main CPU is halted in debug |
| main_frz_en | input | 1 | Main CPU halt freezes all units |
| sec_halted | input | 1 | Secondary CPU is halted in debug |
| sec_frz_en | input | 1 | Secondary CPU halt freezes all units |
| wdog_nmi_mode | input | 1 | System watchdog runs in NMI mode; blocks setting its flag |
| frz_out | output | 11 | Registered freeze line, one per unit |

## Verification
A wrong stored flag appears on `bus_rdata` at either offset in the same cycle the flag changes. It reaches the matching `frz_out` bit one clock later. A wrong halt merge shows only on `frz_out`, one cycle after the halt inputs change, and only while no stored flag already masks it. For that reason the halt cases are run with the store both empty and partly set. The watchdog blocking rule is checked at the read port right after the write that was blocked.

// File: rtl/freeze_pkg.sv
package freeze_pkg;
  // unit positions in the freeze vector
  localparam int UNIT_WKUP_TMR   = 0;
  localparam int UNIT_TMR1       = 1;
  localparam int UNIT_RSVD       = 2;
  localparam int UNIT_SYS_WDOG   = 3;
  localparam int UNIT_USB        = 4;
  localparam int UNIT_DMA        = 5;
  localparam int UNIT_TMR2       = 6;
  localparam int UNIT_LED_PWM    = 7;
  localparam int UNIT_TMR3       = 8;
  localparam int UNIT_TMR4       = 9;
  localparam int UNIT_SEC_WDOG   = 10;
  localparam int UNIT_COUNT      = 11;

  localparam int REG_SET_OFS     = 0;
  localparam int REG_CLR_OFS     = 4;
endpackage

// File: rtl/freeze_bus_decode.sv
module freeze_bus_decode #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int N_UNITS  = 11,
  parameter int RSVD_BIT = 2,
  parameter int SET_OFS  = 0,
  parameter int CLR_OFS  = 4
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [N_UNITS-1:0] store_q,
  output logic [N_UNITS-1:0] set_req,
  output logic [N_UNITS-1:0] clr_req,
  output logic [DATA_W-1:0]  rdata
);
  localparam logic [ADDR_W-1:0] SET_ADDR = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_ADDR = ADDR_W'(CLR_OFS);
  localparam int                PAD_W    = DATA_W - N_UNITS;

  logic [N_UNITS-1:0] impl_mask;
  logic               hit_set;
  logic               hit_clr;
  logic               unused_wdata_hi;

  genvar gi;
  generate
    for (gi = 0; gi < N_UNITS; gi++) begin : g_mask
      if (gi == RSVD_BIT) begin : g_rsvd
        assign impl_mask[gi] = 1'b0;
      end else begin : g_impl
        assign impl_mask[gi] = 1'b1;
      end
    end
  endgenerate

  assign unused_wdata_hi = ^wdata[DATA_W-1:N_UNITS];

  always_comb begin
    hit_set = (addr == SET_ADDR);
    hit_clr = (addr == CLR_ADDR);
    set_req = (we && hit_set) ? (wdata[N_UNITS-1:0] & impl_mask) : '0;
    clr_req = (we && hit_clr) ? (wdata[N_UNITS-1:0] & impl_mask) : '0;
    if (hit_set || hit_clr) begin
      rdata = {{PAD_W{1'b0}}, store_q};
    end else begin
      rdata = '0;
    end
  end

  always_comb begin
    AST_SET_CLR_EXCL: assert (!((|set_req) && (|clr_req))) else $error("set and clear together"); // R4
  end
endmodule

// File: rtl/freeze_store.sv
module freeze_store #(
  parameter int N_UNITS = 11,
  parameter int WD_BIT  = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] set_req,
  input  logic [N_UNITS-1:0] clr_req,
  input  logic               nmi_mode,
  output logic [N_UNITS-1:0] q
);
  logic [N_UNITS-1:0] set_eff;
  logic [N_UNITS-1:0] q_d;
  logic               q_en;

  // next state: clear has priority over set for the same bit
  always_comb begin
    set_eff = set_req;
    if (nmi_mode) begin
      set_eff[WD_BIT] = 1'b0;
    end
    q_d  = (q | set_eff) & ~clr_req;
    q_en = (|set_eff) || (|clr_req);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (q_en) begin
      q <= q_d;
    end
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((q & $past(set_eff & ~clr_req)) == $past(set_eff & ~clr_req))); // R2
  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr_req) |=> ((q & $past(clr_req)) == '0)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_req) && !(|clr_req)) |=> $stable(q)); // R2
  AST_NMI_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_mode && !q[WD_BIT]) |=> !q[WD_BIT]); // R6
endmodule

// File: rtl/freeze_out_stage.sv
module freeze_out_stage #(
  parameter int N_UNITS  = 11,
  parameter int WD_BIT   = 3,
  parameter int RSVD_BIT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_UNITS-1:0] store_q,
  input  logic               main_halted,
  input  logic               main_frz_en,
  input  logic               sec_halted,
  input  logic               sec_frz_en,
  output logic [N_UNITS-1:0] frz_out
);
  logic [N_UNITS-1:0] impl_mask;
  logic [N_UNITS-1:0] halt_vec;
  logic [N_UNITS-1:0] out_d;
  logic               all_frz;

  genvar gi;
  generate
    for (gi = 0; gi < N_UNITS; gi++) begin : g_mask
      if (gi == RSVD_BIT) begin : g_rsvd
        assign impl_mask[gi] = 1'b0;
      end else begin : g_impl
        assign impl_mask[gi] = 1'b1;
      end
    end
  endgenerate

  always_comb begin
    all_frz  = (main_halted && main_frz_en) || (sec_halted && sec_frz_en);
    halt_vec = all_frz ? impl_mask : '0;
    // the system watchdog always stops while the main CPU is halted
    if (main_halted) begin
      halt_vec[WD_BIT] = 1'b1;
    end
    out_d = store_q | halt_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frz_out <= '0;
    end else begin
      frz_out <= out_d;
    end
  end

  AST_MAIN_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (main_halted && main_frz_en) |=> (frz_out == impl_mask)); // R8
  AST_WD_ON_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    main_halted |=> frz_out[WD_BIT]); // R9
  AST_SEC_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_halted && sec_frz_en) |=> (frz_out == impl_mask)); // R10
  AST_RSVD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !frz_out[RSVD_BIT]); // R5
endmodule

// File: rtl/periph_freeze_ctrl.sv
module periph_freeze_ctrl #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int N_UNITS  = freeze_pkg::UNIT_COUNT,
  parameter int WD_BIT   = freeze_pkg::UNIT_SYS_WDOG,
  parameter int RSVD_BIT = freeze_pkg::UNIT_RSVD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               main_halted,
  input  logic               main_frz_en,
  input  logic               sec_halted,
  input  logic               sec_frz_en,
  input  logic               wdog_nmi_mode,
  output logic [N_UNITS-1:0] frz_out
);
  logic [N_UNITS-1:0] set_req;
  logic [N_UNITS-1:0] clr_req;
  logic [N_UNITS-1:0] store_q;

  freeze_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_UNITS(N_UNITS), .RSVD_BIT(RSVD_BIT),
    .SET_OFS(freeze_pkg::REG_SET_OFS), .CLR_OFS(freeze_pkg::REG_CLR_OFS)
  ) u_decode (
    .addr(bus_addr), .we(bus_we), .wdata(bus_wdata), .store_q(store_q),
    .set_req(set_req), .clr_req(clr_req), .rdata(bus_rdata)
  );

  freeze_store #(.N_UNITS(N_UNITS), .WD_BIT(WD_BIT)) u_store (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .clr_req(clr_req),
    .nmi_mode(wdog_nmi_mode), .q(store_q)
  );

  freeze_out_stage #(.N_UNITS(N_UNITS), .WD_BIT(WD_BIT), .RSVD_BIT(RSVD_BIT)) u_out (
    .clk(clk), .rst_n(rst_n), .store_q(store_q),
    .main_halted(main_halted), .main_frz_en(main_frz_en),
    .sec_halted(sec_halted), .sec_frz_en(sec_frz_en), .frz_out(frz_out)
  );

  AST_RDATA_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:N_UNITS] == '0); // R4
endmodule

// File: tb/periph_freeze_ctrl_tb.sv
module periph_freeze_ctrl_tb;
  localparam logic [10:0] IMPL = 11'h7FB;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        main_halted, main_frz_en, sec_halted, sec_frz_en, wdog_nmi_mode;
  logic [10:0] frz_out;

  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc   = 0;
  logic [10:0] exp_q;

  always #2 clk = ~clk;

  periph_freeze_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .main_halted(main_halted),
    .main_frz_en(main_frz_en), .sec_halted(sec_halted), .sec_frz_en(sec_frz_en),
    .wdog_nmi_mode(wdog_nmi_mode), .frz_out(frz_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    chk(req, bus_rdata, exp);
  endtask

  task automatic out_chk(input string req, input logic [10:0] exp);
    @(negedge clk);
    chk(req, {21'd0, frz_out}, {21'd0, exp});
  endtask

  task automatic t_reset;
    rd_chk("R1 rd set", 8'h00, 32'h0);
    rd_chk("R1 rd clr", 8'h04, 32'h0);
    chk("R1 out", {21'd0, frz_out}, 32'h0);
  endtask

  task automatic t_set;
    bus_wr(8'h00, 32'h0000_00F3); exp_q = 11'h0F3;
    rd_chk("R2 set", 8'h00, {21'd0, exp_q});
    out_chk("R7 out after set", exp_q);
    bus_wr(8'h00, 32'hFFFF_F700); exp_q = 11'h7F3;
    rd_chk("R2 zeros keep", 8'h04, {21'd0, exp_q});
    out_chk("R7 out after set2", exp_q);
  endtask

  task automatic t_clr;
    bus_wr(8'h04, 32'h0000_0021); exp_q = 11'h7D2;
    rd_chk("R3 clear", 8'h04, {21'd0, exp_q});
    bus_wr(8'h04, 32'h0);
    rd_chk("R3 zero clear", 8'h00, {21'd0, exp_q});
    out_chk("R7 out after clr", exp_q);
  endtask

  task automatic t_other_addr;
    bus_wr(8'h08, 32'hFFFF_FFFF);
    rd_chk("R4 other rd", 8'h08, 32'h0);
    bus_wr(8'h0C, 32'hFFFF_FFFF);
    rd_chk("R4 other wr ignored", 8'h00, {21'd0, exp_q});
  endtask

  task automatic t_rsvd;
    bus_wr(8'h04, 32'h7FF); exp_q = 11'h000;
    bus_wr(8'h00, 32'h004);
    rd_chk("R5 rsvd read", 8'h00, 32'h0);
    out_chk("R5 rsvd out", 11'h000);
  endtask

  task automatic t_nmi;
    wdog_nmi_mode = 1'b1;
    bus_wr(8'h00, 32'h008);
    rd_chk("R6 set blocked", 8'h00, 32'h0);
    bus_wr(8'h00, 32'h018); exp_q = 11'h010;
    rd_chk("R6 others set", 8'h00, {21'd0, exp_q});
    wdog_nmi_mode = 1'b0;
    bus_wr(8'h00, 32'h008); exp_q = 11'h018;
    rd_chk("R6 set allowed", 8'h00, {21'd0, exp_q});
    wdog_nmi_mode = 1'b1;
    bus_wr(8'h04, 32'h008); exp_q = 11'h010;
    rd_chk("R6 clear in nmi", 8'h00, {21'd0, exp_q});
    wdog_nmi_mode = 1'b0;
  endtask

  task automatic t_main_halt;
    main_halted = 1'b1; main_frz_en = 1'b1;
    out_chk("R8 all frozen", IMPL);
    main_frz_en = 1'b0;
    out_chk("R9 wdog only", exp_q | 11'h008);
    bus_wr(8'h04, 32'h7FF); exp_q = 11'h000;
    out_chk("R9 wdog only empty", 11'h008);
    main_halted = 1'b0; main_frz_en = 1'b1;
    out_chk("R7 halt released", 11'h000);
  endtask

  task automatic t_sec_halt;
    bus_wr(8'h00, 32'h200); exp_q = 11'h200;
    sec_halted = 1'b1; sec_frz_en = 1'b0;
    out_chk("R10 sec halt no en", exp_q);
    sec_frz_en = 1'b1;
    out_chk("R10 sec all frozen", IMPL);
    sec_halted = 1'b0;
    out_chk("R10 sec released", exp_q);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    main_halted = 1'b0; main_frz_en = 1'b1; sec_halted = 1'b0;
    sec_frz_en = 1'b0; wdog_nmi_mode = 1'b0; exp_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_set();
    t_clr();
    t_other_addr();
    t_rsvd();
    t_nmi();
    t_main_halt();
    t_sec_halt();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule